// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets a host on a two-wire serial bus read and write a file of 22 byte-wide control registers. The clock and data lines are brought in as plain inputs and sampled on a faster system clock. Each line passes through a two-flop synchronizer and a glitch filter before the logic looks for start and stop conditions. The slave never drives the data line high. It only asserts `sda_oe`, which the pad logic turns into a low level on the wire.

Four transaction types are supported. A single-byte write or read selects its target register through a nonzero command code. A multi-byte write or read is selected by command code 00h and always starts at register 0. In a multi-byte write the host first sends a byte count and then the data. In a multi-byte read the slave first returns a count and then the registers in index order.

The stored registers come out of reset at fixed defaults, and the whole stored file is visible in parallel to the rest of the chip. On reads, some bits show live hardware state in place of what was stored:

- the captured frequency straps,
- a watchdog-expired flag,
- the running watchdog count.

Top module: `cfg_smb_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 69h, sent as 8-bit D2h for write and D3h for read. Any other address receives no acknowledge and changes no register.
- R2: A nonzero command code N selects byte mode at register N. The first data byte that follows is stored in register N, subject to the write masks of R7 and R8. Any further data bytes are acknowledged and discarded.
- R3: After a byte-mode command N, a repeated start and address D3h, the slave returns the read view of register N.
- R4: Command 00h selects block mode. In a block write the next byte is a count C, and data bytes k = 0..C-1 are stored in register k. Data bytes beyond C are acknowledged and discarded.
- R5: A block read (command 00h, repeated start, D3h) returns the count 16h first, then the read views of registers 0 through 21 in order.
- R6: Reset defaults for registers 0..21 are, in hex: 10 E2 FF F3 FF 82 FE 40 D0 7A 03 0B 72 3F 10 E9 E0 03 7A 22 88 2B.
- R7: Register 7 is read-only and always holds and reads 40h.
- R8: Bits [4:0] of register 1 read the `strap_fs` input, and bit 5 of register 5 reads `wd_expired`. Writes leave the stored copies of these bits unchanged.
- R9: While `wd_active` is high, bits [6:0] of register 20 read `wd_count`. Otherwise register 20 reads its stored value.
- R10: Register indices 22 and above read 00h. Writes to them are acknowledged, and every register is left unchanged.
- R11: `sda_oe` rises only while the filtered clock is low. It is released by the end of each acknowledge slot, except when a read transfer starts, and it is low whenever the bus is idle after a stop.
- R12: A pulse of two system clocks or less on either line, with the default filter length of 3, is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| strap_fs | input | 5 | Captured frequency strap value, shown in register 1 bits [4:0] |
| wd_active | input | 1 | Watchdog is counting; register 20 reads the live count |
| wd_count | input | 7 | Present watchdog countdown value |
| wd_expired | input | 1 | Watchdog reached zero, shown in register 5 bit 5 |
| cfg_regs | output | 176 | Stored register file, register k in bits [8k+7:8k] |

## Verification
A corrupted pointer or byte counter shows up at the ports within a single transfer. A block read returns a wrong or shifted byte at the first affected index. A write lands in a neighbouring register, and this is visible on `cfg_regs` straight after the stop. A state machine that loses its bit or phase position shows within nine clock pulses, as a missing acknowledge or a data line that stays held low when it should be released. The test sweeps every register index, including two beyond the file, in byte mode. Around that sweep it runs block reads and block writes with full, short and over-long counts, and it sweeps the live strap, flag and count inputs.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK
    } smb_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } smb_ph_e;

    // power-on contents of each register
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'hE2;
            2:       return 8'hFF;
            3:       return 8'hF3;
            4:       return 8'hFF;
            5:       return 8'h82;
            6:       return 8'hFE;
            7:       return 8'h40;
            8:       return 8'hD0;
            9:       return 8'h7A;
            10:      return 8'h03;
            11:      return 8'h0B;
            12:      return 8'h72;
            13:      return 8'h3F;
            14:      return 8'h10;
            15:      return 8'hE9;
            16:      return 8'hE0;
            17:      return 8'h03;
            18:      return 8'h7A;
            19:      return 8'h22;
            20:      return 8'h88;
            21:      return 8'h2B;
            default: return 8'h00;
        endcase
    endfunction

    // bits a host write may change
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            1:       return 8'hE0;
            5:       return 8'hDF;
            7:       return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          out;
        logic [CW-1:0] cnt;
    } filt_s;

    filt_s q, d;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], din};
        if (q.sync[1] != q.out) begin
            if (q.cnt == CW'(FILT_CYC - 1)) begin
                d.out = q.sync[1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, out: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign dout = q.out;

    // the filtered level only moves toward a level the synchronizer held
    p_filt_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.out) |-> ($past(q.sync[1]) == q.out));

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } ev_s;

    ev_s q, d;

    always_comb begin
        d.scl_p = scl_f;
        d.sda_p = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise  = scl_f & ~q.scl_p;
    assign scl_fall  = ~scl_f & q.scl_p;
    assign start_det = scl_f & q.scl_p & q.sda_p & ~sda_f;
    assign stop_det  = scl_f & q.scl_p & ~q.sda_p & sda_f;

endmodule

// File: rtl/smb_protocol.sv
module smb_protocol
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    localparam logic [7:0] BLK_COUNT = 8'(NREG);

    typedef struct packed {
        smb_st_e    st;
        smb_ph_e    ph;
        smb_ph_e    ph_nx;
        logic [7:0] sh;
        logic [3:0] bits;
        logic       rw;
        logic       blk;
        logic       cnt_first;
        logic [7:0] ptr;
        logic [7:0] left;
        logic       oe;
        logic       mack;
        logic       wr_en;
        logic [7:0] wr_idx;
        logic [7:0] wr_dat;
    } prot_s;

    prot_s q, d;
    logic  load;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        load    = 1'b0;
        if (stop_det) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st   = S_RX;
            d.ph   = PH_ADDR;
            d.bits = 4'd0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[6:0], sda_f};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.bits = 4'd0;
                        d.st   = S_RX_ACK;
                        d.oe   = 1'b1;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.rw        = q.sh[0];
                                    d.ph_nx     = PH_CMD;
                                    d.cnt_first = q.blk & q.sh[0];
                                end else begin
                                    d.st = S_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            PH_CMD: begin
                                if (q.sh == 8'h00) begin
                                    d.blk   = 1'b1;
                                    d.ptr   = 8'h00;
                                    d.ph_nx = PH_COUNT;
                                end else begin
                                    d.blk   = 1'b0;
                                    d.ptr   = q.sh;
                                    d.left  = 8'd1;
                                    d.ph_nx = PH_DATA;
                                end
                            end
                            PH_COUNT: begin
                                d.left  = q.sh;
                                d.ph_nx = PH_DATA;
                            end
                            default: begin
                                d.ph_nx = PH_DATA;
                                if (q.left != 8'd0) begin
                                    d.wr_en  = 1'b1;
                                    d.wr_idx = q.ptr;
                                    d.wr_dat = q.sh;
                                    d.ptr    = q.ptr + 8'd1;
                                    d.left   = q.left - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        if (q.rw && q.ph == PH_ADDR) begin
                            load = 1'b1;
                        end else begin
                            d.st = S_RX;
                            d.ph = q.ph_nx;
                            d.oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            d.oe   = 1'b0;
                            d.st   = S_TX_ACK;
                            d.bits = 4'd0;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bits = q.bits + 4'd1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = sda_f;
                    end else if (scl_fall) begin
                        if (!q.mack) begin
                            load = 1'b1;
                        end else begin
                            d.st = S_IDLE;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (load) begin
            if (q.cnt_first) begin
                d.sh        = BLK_COUNT;
                d.cnt_first = 1'b0;
            end else begin
                d.sh  = rd_data;
                d.ptr = q.ptr + 8'd1;
            end
            d.oe   = ~d.sh[7];
            d.bits = 4'd0;
            d.st   = S_TX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ph: PH_ADDR, ph_nx: PH_ADDR, sh: 8'h00,
                   bits: 4'd0, rw: 1'b0, blk: 1'b0, cnt_first: 1'b0,
                   ptr: 8'h00, left: 8'h00, oe: 1'b0, mack: 1'b1,
                   wr_en: 1'b0, wr_idx: 8'h00, wr_dat: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign rd_idx  = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_idx  = q.wr_idx;
    assign wr_data = q.wr_dat;
    assign sda_oe  = q.oe;

    // data line is only pulled while the clock is low
    p_oe_rise_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_f);

    // an address acknowledge is only given for the own address
    p_ack_own_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RX_ACK && q.ph == PH_ADDR) |-> (q.sh[7:1] == DEV_ADDR));

    // register writes come only out of the data phase
    p_wr_from_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> ($past(q.st) == S_RX && $past(q.ph) == PH_DATA));

    // ack slot of a write-direction byte ends with the line released
    p_ack_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RX_ACK && scl_fall && !start_det && !stop_det &&
         !(q.rw && q.ph == PH_ADDR)) |=> !q.oe);

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_pkg::*;
#(
    parameter int NREG = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_idx,
    output logic [7:0]      rd_data,
    input  logic [4:0]      strap_fs,
    input  logic            wd_active,
    input  logic [6:0]      wd_count,
    input  logic            wd_expired,
    output logic [NREG*8-1:0] regs_flat
);
    localparam int IW        = $clog2(NREG);
    localparam int IDX_STRAP = 1;
    localparam int IDX_FULLW = 2;
    localparam int IDX_WDCTL = 5;
    localparam int IDX_ID    = 7;
    localparam int IDX_WDCNT = 20;

    logic [7:0] regs_q [NREG];
    logic [7:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && wr_idx == 8'(i)) begin
                regs_d[i] = (regs_q[i] & ~reg_wmask(i)) | (wr_data & reg_wmask(i));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= reg_default(i);
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*8 +: 8] = regs_q[g];
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_idx < 8'(NREG)) begin
            rd_data = regs_q[rd_idx[IW-1:0]];
            if (rd_idx == 8'(IDX_STRAP)) rd_data[4:0] = strap_fs;
            if (rd_idx == 8'(IDX_WDCTL)) rd_data[5]   = wd_expired;
            if (rd_idx == 8'(IDX_WDCNT) && wd_active) rd_data[6:0] = wd_count;
        end
    end

    p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'(IDX_FULLW)) |=> (regs_q[IDX_FULLW] == $past(wr_data)));

    p_ro_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[IDX_STRAP][4:0] == $past(regs_q[IDX_STRAP][4:0]) &&
                   regs_q[IDX_WDCTL][5] == $past(regs_q[IDX_WDCTL][5])));

    p_id_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'(IDX_ID)) |=> (regs_q[IDX_ID] == reg_default(IDX_ID)));

    p_oor_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= 8'(NREG)) |=> $stable(regs_flat));

endmodule

// File: rtl/cfg_smb_slave.sv
module cfg_smb_slave #(
    parameter int         NREG     = 22,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         FILT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [4:0]        strap_fs,
    input  logic              wd_active,
    input  logic [6:0]        wd_count,
    input  logic              wd_expired,
    output logic [NREG*8-1:0] cfg_regs
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] line_raw;
    logic [NLINE-1:0] line_flt;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
    logic wr_en;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        smb_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_flt[g])
        );
    end

    smb_bus_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (line_flt[0]),
        .sda_f    (line_flt[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smb_protocol #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (line_flt[0]),
        .sda_f    (line_flt[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    smb_regfile #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .strap_fs  (strap_fs),
        .wd_active (wd_active),
        .wd_count  (wd_count),
        .wd_expired(wd_expired),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/tb_cfg_smb_slave.sv
module tb_cfg_smb_slave;
    localparam int NREG = 22;
    localparam int Q    = 10;
    localparam int WDOG = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, gl_scl = 1'b0, gl_sda = 1'b0, glitch_on = 1'b0;
    logic sda_oe;
    logic [4:0] strap = 5'h12;
    logic wd_active = 1'b0;
    logic [6:0] wd_count = 7'h00;
    logic wd_expired = 1'b0;
    logic [NREG*8-1:0] cfg_regs;

    wire scl_bus = scl_m ^ gl_scl;
    wire sda_bus = (sda_m ^ gl_sda) & ~sda_oe;

    cfg_smb_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .strap_fs  (strap),
        .wd_active (wd_active),
        .wd_count  (wd_count),
        .wd_expired(wd_expired),
        .cfg_regs  (cfg_regs)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] buf_q [32];

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // defaults per R6
    function automatic logic [7:0] exp_default(input int idx);
        logic [7:0] t [NREG] = '{8'h10, 8'hE2, 8'hFF, 8'hF3, 8'hFF, 8'h82, 8'hFE, 8'h40,
                                 8'hD0, 8'h7A, 8'h03, 8'h0B, 8'h72, 8'h3F, 8'h10, 8'hE9,
                                 8'hE0, 8'h03, 8'h7A, 8'h22, 8'h88, 8'h2B};
        return t[idx];
    endfunction

    // writable bits per R7 and R8
    function automatic logic [7:0] exp_mask(input int idx);
        if (idx == 1) return 8'hE0;
        if (idx == 5) return 8'hDF;
        if (idx == 7) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic void mwrite(input int idx, input logic [7:0] v);
        if (idx < NREG) model[idx] = (model[idx] & ~exp_mask(idx)) | (v & exp_mask(idx));
    endfunction

    // read view per R8, R9, R10
    function automatic logic [7:0] rv(input int idx);
        logic [7:0] v;
        if (idx >= NREG) return 8'h00;
        v = model[idx];
        if (idx == 1) v[4:0] = strap;
        if (idx == 5) v[5] = wd_expired;
        if (idx == 20 && wd_active) v[6:0] = wd_count;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
        chk("R11 idle release", 32'(sda_oe), 32'h0);
    endtask

    task automatic m_bit_w(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        if (glitch_on) begin
            tick(Q / 2);
            gl_scl = 1'b1; tick(2); gl_scl = 1'b0;
            tick(2);
            gl_sda = 1'b1; tick(2); gl_sda = 1'b0;
            tick(2 * Q - Q / 2 - 6);
        end else begin
            tick(2 * Q);
        end
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_bit_r(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
        m_bit_r(b);
        ack = ~b;
        if (v != 8'hD3) chk("R11 release after ack", 32'(sda_oe), 32'h0);
    endtask

    task automatic m_rbyte(input logic last, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_r(b);
            v[i] = b;
        end
        m_bit_w(last);
    endtask

    task automatic byte_write(input int idx, input logic [7:0] v, input string req);
        logic a;
        m_start();
        m_wbyte(8'hD2, a); chk({req, " addr ack"}, 32'(a), 32'h1);
        m_wbyte(8'(idx), a); chk({req, " cmd ack"}, 32'(a), 32'h1);
        m_wbyte(v, a);     chk({req, " data ack"}, 32'(a), 32'h1);
        m_stop();
        mwrite(idx, v);
    endtask

    task automatic byte_read(input int idx, output logic [7:0] v);
        logic a;
        m_start();
        m_wbyte(8'hD2, a); chk("R3 addr ack", 32'(a), 32'h1);
        m_wbyte(8'(idx), a); chk("R3 cmd ack", 32'(a), 32'h1);
        m_start();
        m_wbyte(8'hD3, a); chk("R3 read addr ack", 32'(a), 32'h1);
        m_rbyte(1'b1, v);
        m_stop();
    endtask

    task automatic block_read(output logic [7:0] cnt);
        logic a;
        m_start();
        m_wbyte(8'hD2, a); chk("R5 addr ack", 32'(a), 32'h1);
        m_wbyte(8'h00, a); chk("R5 cmd ack", 32'(a), 32'h1);
        m_start();
        m_wbyte(8'hD3, a); chk("R5 read addr ack", 32'(a), 32'h1);
        m_rbyte(1'b0, cnt);
        for (int k = 0; k < NREG; k++) m_rbyte(k == NREG - 1, buf_q[k]);
        m_stop();
    endtask

    task automatic block_write(input int cnt, input int nbytes);
        logic a;
        m_start();
        m_wbyte(8'hD2, a); chk("R4 addr ack", 32'(a), 32'h1);
        m_wbyte(8'h00, a); chk("R4 cmd ack", 32'(a), 32'h1);
        m_wbyte(8'(cnt), a); chk("R4 count ack", 32'(a), 32'h1);
        for (int k = 0; k < nbytes; k++) begin
            m_wbyte(buf_q[k], a);
            chk("R4 data ack", 32'(a), 32'h1);
            if (k < cnt) mwrite(k, buf_q[k]);
        end
        m_stop();
    endtask

    task automatic check_cfg(input string req);
        for (int i = 0; i < NREG; i++) chk(req, 32'(cfg_regs[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic check_block(input string req);
        logic [7:0] cnt;
        block_read(cnt);
        chk("R5 count", 32'(cnt), 32'h16);
        for (int k = 0; k < NREG; k++) chk(req, 32'(buf_q[k]), 32'(rv(k)));
    endtask

    initial begin
        logic [7:0] v;
        logic a;
        string tag;

        for (int i = 0; i < NREG; i++) model[i] = exp_default(i);
        tick(5);
        chk("R11 reset release", 32'(sda_oe), 32'h0);
        rst_n = 1'b1;
        tick(5);

        // R6 reset state, directly and over the bus
        check_cfg("R6 default");
        check_block("R6 block view");

        // byte mode sweep over every index, two past the end
        for (int idx = 1; idx < NREG + 2; idx++) begin
            v = 8'(idx * 29 + 7) ^ 8'hA5;
            tag = (idx >= NREG) ? "R10" : "R2";
            byte_write(idx, v, tag);
            byte_read(idx, v);
            if (idx >= NREG)   chk("R10 out of range read", 32'(v), 32'h00);
            else if (idx == 7) chk("R7 id read", 32'(v), 32'h40);
            else if (idx == 1 || idx == 5) chk("R8 live bits", 32'(v), 32'(rv(idx)));
            else               chk("R3 byte read", 32'(v), 32'(rv(idx)));
        end
        check_cfg("R2 stored after sweep");

        // R2: second data byte in byte mode is discarded
        m_start();
        m_wbyte(8'hD2, a);
        m_wbyte(8'h02, a);
        m_wbyte(8'h3C, a); chk("R2 first data ack", 32'(a), 32'h1);
        m_wbyte(8'h99, a); chk("R2 extra data ack", 32'(a), 32'h1);
        m_stop();
        mwrite(2, 8'h3C);
        check_cfg("R2 extra byte discarded");

        // R4 full block write, then R5 block read
        for (int k = 0; k < NREG; k++) buf_q[k] = 8'(k * 11 + 3);
        block_write(NREG, NREG);
        check_cfg("R4 full block");
        check_block("R5 block view");

        // R4 short count with surplus bytes
        for (int k = 0; k < 5; k++) buf_q[k] = 8'hF0 + 8'(k);
        block_write(3, 5);
        check_cfg("R4 surplus discarded");

        // R1 foreign addresses
        m_start(); m_wbyte(8'hD4, a); chk("R1 nack 6Ah", 32'(a), 32'h0); m_stop();
        m_start(); m_wbyte(8'hD0, a); chk("R1 nack 68h", 32'(a), 32'h0);
        m_wbyte(8'h02, a); m_wbyte(8'h00, a); m_stop();
        check_cfg("R1 foreign unchanged");

        // R8 strap and flag sweep
        for (int s = 0; s < 32; s += 5) begin
            strap = 5'(s);
            byte_read(1, v);
            chk("R8 strap view", 32'(v), 32'(rv(1)));
        end
        for (int e = 0; e < 2; e++) begin
            wd_expired = e[0];
            byte_read(5, v);
            chk("R8 expired view", 32'(v), 32'(rv(5)));
        end

        // R9 live watchdog count
        wd_active = 1'b1;
        for (int c = 0; c < 4; c++) begin
            wd_count = (c == 0) ? 7'h00 : (c == 1) ? 7'h01 : (c == 2) ? 7'h55 : 7'h7F;
            byte_read(20, v);
            chk("R9 live count", 32'(v), 32'({model[20][7], wd_count}));
        end
        wd_active = 1'b0;
        byte_read(20, v);
        chk("R9 stored count", 32'(v), 32'(model[20]));

        // R12 glitches on both lines during a write
        glitch_on = 1'b1;
        byte_write(9, 8'h5A, "R12");
        glitch_on = 1'b0;
        byte_read(9, v);
        chk("R12 glitch write", 32'(v), 32'h5A);
        check_cfg("R12 glitch stored");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule